// File: doc/BRIEF.md
# Thirty-Two Line Interrupt Aggregator

The block collects 32 interrupt request lines from peripherals in the same chip and merges them into one request line for a parent interrupt controller. Each line goes through a two-stage synchroniser to the local clock. It is then qualified by its own trigger setting, which can be a rising edge, a falling edge, a high level or a low level. The qualified result is held in a per-line pending bit. A pending bit only reaches the parent when the line's enable bit is set. A force bit lets software raise any line without input activity. Software clears a latched edge by writing a one to that line's pending bit.

The merged request passes through an output shaper before it leaves the block. In level mode the shaper drives the request as a level. In pulse mode it drives a single-cycle pulse each time the merged request goes from idle to active. In both modes the output polarity is programmable.

Software uses a plain 32-bit register port with seven word registers. There is one write strobe, and reads are combinational on the address. The register port is plain control access, so it has no valid/ready handshake and never applies back-pressure: a write takes effect at the clock edge where the strobe is high, and read data follows the address in the same cycle.

Top module: `irq_agg32`

## Requirements
- R1: The register port decodes byte address bits [4:2]. The word offsets are 0x00 enable, 0x04 pending status, 0x08 source trigger kind, 0x0C source polarity, 0x10 output mode, 0x14 output polarity and 0x18 force. Every register except pending status reads back the last value written to it.
- R2: While reset is held, enable, output mode, output polarity, force, source kind, source polarity and pending status are all zero, so the output idles high (level mode, low-active).
- R3: A source with kind bit 1 and polarity bit 1 sets its pending bit on a synchronised 0-to-1 transition, and ignores 1-to-0 transitions.
- R4: A source with kind bit 1 and polarity bit 0 sets its pending bit on a synchronised 1-to-0 transition, and ignores 0-to-1 transitions.
- R5: An edge-latched pending bit stays set after the input returns idle, until a write of 1 to that bit of the status register. Writing 0 to a status bit leaves it unchanged.
- R6: A source with kind bit 0 has a pending bit that follows its synchronised level each cycle: the bit is 1 when the level equals the polarity bit. A write of 1 to the status bit does not clear it while the level stays active.
- R7: A force bit that is set makes the matching pending bit read 1 one cycle after it is written, whatever the input does.
- R8: A pending source whose enable bit is 0 has no effect on the output.
- R9: With output mode bit 0 at 0, the output is the OR over all lines of pending AND enable. Output polarity bit 0 at 1 drives it high-active, and at 0 inverts it.
- R10: With output mode bit 0 at 1, each idle-to-active change of the merged request gives exactly one cycle at the output-polarity level. Otherwise the output stays at the opposite level.
- R11: A change at a source input first shows in the pending status on the third clock edge after it is applied.
- R12: Address offset 0x1C reads zero, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Asynchronous interrupt request lines |
| bus_wr | input | 1 | Write strobe, sampled at the rising clock edge |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, same cycle |
| irq_o | output | 1 | Shaped request to the parent controller |

## Verification
The assertions check four properties on every cycle: that a masked block keeps the output at its idle level, that a forced line is always pending one cycle later, that an edge-latched bit survives every cycle without a clear, and that pulse mode never holds its active level for two cycles in a row. The reset contents are checked the same way. The bench's scenarios are needed to show the trigger selection itself: which edge sets a bit, the three-edge synchroniser latency, the level-tracking W1C behaviour, the register decode and the unmapped offset. A reference model that steps with the clock compares the output and the read data on every cycle, including under random stimulus.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  // word index taken from the byte address bits [4:2]
  typedef enum logic [2:0] {
    RI_EN    = 3'd0,
    RI_STAT  = 3'd1,
    RI_SKIND = 3'd2,
    RI_SPOL  = 3'd3,
    RI_OMODE = 3'd4,
    RI_OPOL  = 3'd5,
    RI_FORCE = 3'd6,
    RI_NONE  = 3'd7
  } reg_idx_e;

  localparam int unsigned IDX_LSB = 2;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= '0;
          else        stg[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[g] <= '0;
          else        stg[g] <= stg[g-1];
        end
      end
    end
  endgenerate

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/irq_src_cell.sv
module irq_src_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,    // synchronised input
  input  logic kind_i,   // 1 edge, 0 level
  input  logic pol_i,    // 1 rising/high, 0 falling/low
  input  logic force_i,
  input  logic ack_i,    // write-one-to-clear strobe
  output logic pend_o
);
  logic prev_q;
  logic edge_hit;
  logic lvl_hit;
  logic pend_d;

  always_comb begin
    edge_hit = pol_i ? (lvl_i & ~prev_q) : (~lvl_i & prev_q);
    lvl_hit  = (lvl_i == pol_i);
    if (kind_i) pend_d = (pend_o & ~ack_i) | edge_hit | force_i;
    else        pend_d = lvl_hit | force_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_o <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      pend_o <= pend_d;
    end
  end
endmodule

// File: rtl/irq_out_shape.sv
module irq_out_shape (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic pulse_mode_i,
  input  logic high_act_i,
  output logic irq_o
);
  logic req_d;
  logic raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_d <= 1'b0;
    else        req_d <= req_i;
  end

  always_comb begin
    raw   = pulse_mode_i ? (req_i & ~req_d) : req_i;
    irq_o = high_act_i ? raw : ~raw;
  end
endmodule

// File: rtl/irq_agg32.sv
module irq_agg32
  import irq_agg_pkg::*;
#(
  parameter int unsigned NSRC      = 32,
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_i,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NSRC-1:0]   bus_wdata,
  output logic [NSRC-1:0]   bus_rdata,
  output logic              irq_o
);
  localparam int unsigned IDX_W = $bits(reg_idx_e);

  reg_idx_e        idx;
  logic [NSRC-1:0] en_q, kind_q, spol_q, omode_q, opol_q, force_q;
  logic [NSRC-1:0] ack_vec, lvl_vec, pend_vec;
  logic            req;

  assign idx     = reg_idx_e'(bus_addr[IDX_LSB +: IDX_W]);
  assign ack_vec = (bus_wr && idx == RI_STAT) ? bus_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      kind_q  <= '0;
      spol_q  <= '0;
      omode_q <= '0;
      opol_q  <= '0;
      force_q <= '0;
    end else if (bus_wr) begin
      unique case (idx)
        RI_EN:    en_q    <= bus_wdata;
        RI_SKIND: kind_q  <= bus_wdata;
        RI_SPOL:  spol_q  <= bus_wdata;
        RI_OMODE: omode_q <= bus_wdata;
        RI_OPOL:  opol_q  <= bus_wdata;
        RI_FORCE: force_q <= bus_wdata;
        default:  ;
      endcase
    end
  end

  always_comb begin
    unique case (idx)
      RI_EN:    bus_rdata = en_q;
      RI_STAT:  bus_rdata = pend_vec;
      RI_SKIND: bus_rdata = kind_q;
      RI_SPOL:  bus_rdata = spol_q;
      RI_OMODE: bus_rdata = omode_q;
      RI_OPOL:  bus_rdata = opol_q;
      RI_FORCE: bus_rdata = force_q;
      default:  bus_rdata = '0;
    endcase
  end

  irq_sync #(.W(NSRC), .STAGES(SYNC_DEPTH)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (src_i),
    .q_o   (lvl_vec)
  );

  genvar s;
  generate
    for (s = 0; s < NSRC; s++) begin : g_src
      irq_src_cell u_cell (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl_i   (lvl_vec[s]),
        .kind_i  (kind_q[s]),
        .pol_i   (spol_q[s]),
        .force_i (force_q[s]),
        .ack_i   (ack_vec[s]),
        .pend_o  (pend_vec[s])
      );
    end
  endgenerate

  assign req = |(pend_vec & en_q);

  irq_out_shape u_shape (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_i        (req),
    .pulse_mode_i (omode_q[0]),
    .high_act_i   (opol_q[0]),
    .irq_o        (irq_o)
  );
endmodule

// File: rtl/irq_agg32_chk.sv
module irq_agg32_chk #(
  parameter int unsigned NSRC = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] en_q,
  input logic [NSRC-1:0] kind_q,
  input logic [NSRC-1:0] omode_q,
  input logic [NSRC-1:0] opol_q,
  input logic [NSRC-1:0] force_q,
  input logic [NSRC-1:0] ack_vec,
  input logic [NSRC-1:0] pend_vec,
  input logic            irq_o
);
  // R2
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (en_q == '0 && pend_vec == '0 && omode_q == '0 && opol_q == '0 && force_q == '0));

  // R5
  edge_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pend_vec & kind_q) & ~$past(ack_vec) & ~pend_vec) == '0));

  // R7
  force_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(force_q) & ~pend_vec) == '0));

  // R8
  masked_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> (irq_o == ~opol_q[0]));

  // R10
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (omode_q[0] && irq_o == opol_q[0]) |=>
      (!omode_q[0] || !$stable(opol_q[0]) || irq_o != opol_q[0]));
endmodule

bind irq_agg32 irq_agg32_chk #(.NSRC(NSRC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en_q     (en_q),
  .kind_q   (kind_q),
  .omode_q  (omode_q),
  .opol_q   (opol_q),
  .force_q  (force_q),
  .ack_vec  (ack_vec),
  .pend_vec (pend_vec),
  .irq_o    (irq_o)
);

// File: tb/tb_irq_agg32.sv
module tb_irq_agg32;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_i = '0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_agg32 dut (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  // behavioural reference model
  logic [31:0] m_s1, m_s2, m_prev, m_pend, m_en, m_kind, m_pol, m_omode, m_opol, m_force;
  bit m_reqd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_prev = '0; m_pend = '0; m_en = '0; m_kind = '0;
      m_pol = '0; m_omode = '0; m_opol = '0; m_force = '0; m_reqd = 0;
    end else begin
      logic [31:0] np;
      logic [31:0] clr;
      clr = (bus_wr && bus_addr[4:2] == 3'd1) ? bus_wdata : 32'h0;
      for (int i = 0; i < 32; i++) begin
        bit ev;
        ev = m_pol[i] ? (m_s2[i] && !m_prev[i]) : (!m_s2[i] && m_prev[i]);
        if (m_kind[i]) np[i] = (m_pend[i] && !clr[i]) || ev || m_force[i];
        else           np[i] = (m_s2[i] == m_pol[i]) || m_force[i];
      end
      m_reqd = |(m_pend & m_en);
      m_pend = np;
      m_prev = m_s2;
      m_s2 = m_s1;
      m_s1 = src_i;
      if (bus_wr) begin
        case (bus_addr[4:2])
          3'd0: m_en = bus_wdata;
          3'd2: m_kind = bus_wdata;
          3'd3: m_pol = bus_wdata;
          3'd4: m_omode = bus_wdata;
          3'd5: m_opol = bus_wdata;
          3'd6: m_force = bus_wdata;
          default: ;
        endcase
      end
    end
  end

  function automatic logic exp_irq();
    bit req, raw;
    req = |(m_pend & m_en);
    raw = m_omode[0] ? (req && !m_reqd) : req;
    return m_opol[0] ? raw : !raw;
  endfunction

  function automatic logic [31:0] exp_rd(logic [4:0] a);
    case (a[4:2])
      3'd0: return m_en;
      3'd1: return m_pend;
      3'd2: return m_kind;
      3'd3: return m_pol;
      3'd4: return m_omode;
      3'd5: return m_opol;
      3'd6: return m_force;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always begin
    @(posedge clk);
    #2;
    if (rst_n && !done) begin
      chk("R9 R10 irq_o per cycle", {31'h0, irq_o}, {31'h0, exp_irq()});
      chk("R1 rdata per cycle", bus_rdata, exp_rd(bus_addr));
    end
  end

  task automatic wr(logic [4:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [4:0] a, logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2000000;
    miscompares++;
    $display("FAIL watchdog expired");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    cyc(3);
    // R2: reset contents
    rd_chk("R2 status in reset", 5'h04, 32'h0);
    rd_chk("R2 enable in reset", 5'h00, 32'h0);
    rd_chk("R2 out mode in reset", 5'h10, 32'h0);
    rd_chk("R2 out pol in reset", 5'h14, 32'h0);
    chk("R2 irq idle high", {31'h0, irq_o}, 32'h1);
    rst_n = 1'b1;
    cyc(4);

    // all sources rising edge, clear everything
    wr(5'h08, 32'hFFFF_FFFF);
    wr(5'h0C, 32'hFFFF_FFFF);
    wr(5'h04, 32'hFFFF_FFFF);
    rd_chk("R5 status cleared", 5'h04, 32'h0);
    rd_chk("R1 kind readback", 5'h08, 32'hFFFF_FFFF);

    // R3 + R11
    src_i[3] = 1'b1;
    cyc(2);
    rd_chk("R11 not yet after two edges", 5'h04, 32'h0);
    cyc(1);
    rd_chk("R3 rising edge latched on third edge", 5'h04, 32'h8);
    src_i[3] = 1'b0;
    cyc(4);
    rd_chk("R5 sticky after input idle", 5'h04, 32'h8);
    wr(5'h04, 32'h0);
    rd_chk("R5 write zero keeps bit", 5'h04, 32'h8);
    wr(5'h04, 32'h8);
    rd_chk("R5 write one clears", 5'h04, 32'h0);

    // R4 falling on source 5
    wr(5'h0C, 32'hFFFF_FFDF);
    src_i[5] = 1'b1;
    cyc(4);
    rd_chk("R4 rising ignored", 5'h04, 32'h0);
    src_i[5] = 1'b0;
    cyc(3);
    rd_chk("R4 falling latched", 5'h04, 32'h20);
    wr(5'h04, 32'h20);

    // R6 level high then low on source 7
    wr(5'h08, 32'hFFFF_FF7F);
    cyc(1);
    rd_chk("R6 level high idle", 5'h04, 32'h0);
    src_i[7] = 1'b1;
    cyc(3);
    rd_chk("R6 level high active", 5'h04, 32'h80);
    wr(5'h04, 32'h80);
    rd_chk("R6 clear ignored while active", 5'h04, 32'h80);
    src_i[7] = 1'b0;
    cyc(3);
    rd_chk("R6 level follows input", 5'h04, 32'h0);
    wr(5'h0C, 32'hFFFF_FF5F);
    cyc(1);
    rd_chk("R6 level low active", 5'h04, 32'h80);
    src_i[7] = 1'b1;
    cyc(3);
    wr(5'h08, 32'hFFFF_FFFF);
    wr(5'h0C, 32'hFFFF_FFFF);
    wr(5'h04, 32'hFFFF_FFFF);
    rd_chk("R6 back to idle", 5'h04, 32'h0);

    // R8 / R9
    src_i[3] = 1'b1;
    cyc(3);
    chk("R8 masked source keeps irq idle", {31'h0, irq_o}, 32'h1);
    wr(5'h00, 32'h8);
    chk("R9 low-active asserted", {31'h0, irq_o}, 32'h0);
    wr(5'h14, 32'h1);
    chk("R9 high-active asserted", {31'h0, irq_o}, 32'h1);
    wr(5'h04, 32'h8);
    chk("R9 deasserted after clear", {31'h0, irq_o}, 32'h0);

    // R10 pulse mode
    src_i[3] = 1'b0;
    cyc(4);
    wr(5'h10, 32'h1);
    src_i[3] = 1'b1;
    cyc(3);
    chk("R10 pulse active", {31'h0, irq_o}, 32'h1);
    cyc(1);
    chk("R10 pulse one cycle only", {31'h0, irq_o}, 32'h0);
    wr(5'h04, 32'h8);
    wr(5'h10, 32'h0);

    // R7 force on source 9
    wr(5'h00, 32'h200);
    wr(5'h18, 32'h200);
    cyc(1);
    rd_chk("R7 forced pending", 5'h04, 32'h200);
    chk("R7 forced irq", {31'h0, irq_o}, 32'h1);
    wr(5'h18, 32'h0);
    wr(5'h04, 32'h200);
    rd_chk("R7 cleared after force off", 5'h04, 32'h0);
    rd_chk("R1 force readback", 5'h18, 32'h0);

    // R12 unmapped offset
    wr(5'h1C, 32'hDEAD_BEEF);
    rd_chk("R12 unmapped reads zero", 5'h1C, 32'h0);
    rd_chk("R12 enable untouched", 5'h00, 32'h200);
    rd_chk("R12 force untouched", 5'h18, 32'h0);

    // random phase, compared every cycle against the model
    for (int n = 0; n < 2000; n++) begin
      int r;
      r = $urandom_range(0, 9);
      src_i = src_i ^ ($urandom() & $urandom());
      if (r < 3) begin
        bus_wr = 1'b1;
        bus_addr = 5'($urandom_range(0, 7) << 2);
        bus_wdata = $urandom();
        if (bus_addr == 5'h18) bus_wdata = bus_wdata & $urandom() & $urandom();
      end else begin
        bus_wr = 1'b0;
        bus_addr = 5'($urandom_range(0, 7) << 2);
      end
      @(negedge clk);
    end
    bus_wr = 1'b0;
    cyc(2);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule